// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block lets a host processor hand one command at a time to an embedded controller and collect the result. The host sees a 256-byte register window on a simple 32-bit bus. It can write a command word and up to 16 outbound data bytes. It can read a status word and up to 16 response bytes. On the other side, the controller receives a one-cycle doorbell, the latched command word and the outbound bytes.

When the controller finishes, it returns a one-cycle done pulse. The pulse carries an error flag, an 8-bit error code, an 8-bit initiator id and the response bytes, and all of them are captured at once. The host polls the busy bit until it clears, then checks the error bit and reads the response. If the command asked for it, the host can instead wait for a one-cycle completion interrupt. Decoding of commands and any bridging to a system bus lie outside this block.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the status word reads 0. No doorbell or interrupt is raised, `ctl_cmd` is 0, and every inbound byte reads 0.
- R2: A host write to offset 0x00 while busy is 0 behaves as follows:
  - In the next cycle, status bit 0 (busy) is 1.
  - `ctl_doorbell` is high for exactly that one cycle.
  - `ctl_cmd` holds the written word, whose fields are: opcode [7:0], completion request [8], reserved [11:9], sub-id [15:12], size [23:16], reserved [31:24].
- R3: A write to offset 0x00 while busy is 1 is ignored. It raises no doorbell and leaves `ctl_cmd` unchanged.
- R4: Host writes to 0x80–0x8F update the outbound bytes. Each set `hst_be[j]` lane writes byte (addr−0x80 rounded down to 4)+j from `hst_wdata[8j+7:8j]`. Byte n appears at `ctl_obuf[8n+7:8n]`. Host reads of these offsets return 0.
- R5: A `ctl_done` pulse while busy clears busy in the next cycle. It also latches the status fields: bit 1 error, bits [7:4] sub-id of the issued command, [15:8] initiator id, [23:16] error code.
- R6: The same done pulse loads `ctl_rsp` into the inbound bytes at 0x90–0x9F.
  - A word read (`hst_rd_byte`=0) at 0x90+4k returns bytes 4k..4k+3 with the lowest byte in bits [7:0].
  - A byte read (`hst_rd_byte`=1) at any address returns that byte in bits [7:0], with the upper bits 0.
- R7: If bit 8 of the issued command was 1, `hst_irq` is high for exactly the one cycle after the accepted done pulse. If bit 8 was 0, `hst_irq` stays low.
- R8: A `ctl_done` pulse while busy is 0 is ignored. The status word, the inbound bytes and `hst_irq` do not change.
- R9: The following all return 0:
  - reads of offset 0x00;
  - reads of any offset outside the status word and the inbound buffer;
  - status bits [3:2] and [31:24];
  - `hst_rdata` whenever `hst_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_rd_byte | input | 1 | 1 = byte read, 0 = aligned word read |
| hst_addr | input | ADDR_W | Host byte address within the window |
| hst_wdata | input | 32 | Host write data |
| hst_be | input | 4 | Byte lane enables for buffer writes |
| hst_rdata | output | 32 | Host read data (combinational) |
| hst_irq | output | 1 | One-cycle completion interrupt |
| ctl_doorbell | output | 1 | One-cycle new-command pulse |
| ctl_cmd | output | 32 | Latched command word |
| ctl_obuf | output | BUF_BYTES*8 | Outbound bytes, byte n at [8n+7:8n] |
| ctl_done | input | 1 | Controller completion pulse |
| ctl_err | input | 1 | Error flag sampled with done |
| ctl_err_code | input | 8 | Error code sampled with done |
| ctl_init_id | input | 8 | Initiator id sampled with done |
| ctl_rsp | input | BUF_BYTES*8 | Response bytes sampled with done |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 16-byte buffers, outbound buffer at 0x80 and inbound buffer at 0x90. This layout places the last byte of each buffer (0x8F and 0x9F) next to a neighbouring region, so reads just past each buffer edge are tested against the zero rule. A full-buffer transfer covers every word index of both buffers. Several command words vary the completion bit, the sub-id and the reserved bits, which shows that the status echo and the interrupt follow only their own fields.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

   localparam int unsigned WORD_W = 32;
   localparam logic [7:0]  CMD_OFF  = 8'h00;
   localparam logic [7:0]  STAT_OFF = 8'h04;

   // Command word as written by the host.
   typedef struct packed {
      logic [7:0] rsv_hi;
      logic [7:0] size;
      logic [3:0] sub_id;
      logic [2:0] rsv_lo;
      logic       ioc;
      logic [7:0] opcode;
   } mbx_cmd_t;

   // Status word as seen by the host.
   typedef struct packed {
      logic [7:0] rsv_hi;
      logic [7:0] err_code;
      logic [7:0] init_id;
      logic [3:0] cmd_id;
      logic [1:0] rsv_lo;
      logic       err;
      logic       busy;
   } mbx_status_t;

endpackage

// File: rtl/mbx_cmd_ctrl.sv
module mbx_cmd_ctrl
   import ipc_mbx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [31:0] cmd_wdata,
   input  logic        done,
   input  logic        done_err,
   input  logic [7:0]  done_code,
   input  logic [7:0]  done_init,
   output mbx_cmd_t    cmd_q,
   output logic        doorbell,
   output mbx_status_t status,
   output logic        irq,
   output logic        load_rsp
);

   logic       busy_q;
   logic       db_q;
   logic       irq_q;
   logic       err_q;
   logic [7:0] code_q;
   logic [7:0] init_q;
   logic [3:0] id_q;
   mbx_cmd_t   cmd_r;

   logic accept;
   logic finish;

   assign accept = cmd_wr & ~busy_q;
   assign finish = done & busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         db_q   <= 1'b0;
         irq_q  <= 1'b0;
         err_q  <= 1'b0;
         code_q <= '0;
         init_q <= '0;
         id_q   <= '0;
         cmd_r  <= '0;
      end else begin
         db_q  <= accept;
         irq_q <= finish & cmd_r.ioc;
         if (accept) begin
            cmd_r  <= mbx_cmd_t'(cmd_wdata);
            busy_q <= 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
            err_q  <= done_err;
            code_q <= done_code;
            init_q <= done_init;
            id_q   <= cmd_r.sub_id;
         end
      end
   end

   always_comb begin
      status          = '0;
      status.busy     = busy_q;
      status.err      = err_q;
      status.cmd_id   = id_q;
      status.init_id  = init_q;
      status.err_code = code_q;
   end

   assign cmd_q    = cmd_r;
   assign doorbell = db_q;
   assign irq      = irq_q;
   assign load_rsp = finish;

   a_r2_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy_q && db_q));

   a_r2_doorbell_single: assert property (@(posedge clk) disable iff (!rst_n)
      db_q |=> !db_q);

   a_r3_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy_q) |=> (!db_q && $stable(cmd_r)));

   a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !busy_q);

   a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   a_r7_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> !busy_q);

   a_r8_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !busy_q && !cmd_wr) |=> $stable(status));

endmodule

// File: rtl/mbx_buf.sv
module mbx_buf #(
   parameter int BYTES = 16,
   parameter int IDX_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [31:0]        wr_data,
   input  logic [3:0]         wr_be,
   input  logic               load,
   input  logic [BYTES*8-1:0] load_data,
   output logic [BYTES*8-1:0] q
);

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r <= '0;
         else if (load)
            r <= load_data[8*b +: 8];
         else if (wr_en && (wr_idx == IDX_W'(b / 4)) && wr_be[b % 4])
            r <= wr_data[8*(b % 4) +: 8];
      end
      assign q[8*b +: 8] = r;
   end

   a_r6_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(load_data)));

   a_r4_no_lane_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && (!wr_en || wr_be == 4'b0000)) |=> $stable(q));

endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
   import ipc_mbx_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTES     = 16,
   parameter int IBUF_BASE = 144
) (
   input  logic               rd_en,
   input  logic               rd_byte,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [31:0]        status_w,
   input  logic [BYTES*8-1:0] ibuf,
   output logic [31:0]        rdata
);

   localparam int WORDS = BYTES / 4;

   logic [ADDR_W-1:0] aligned;
   logic [31:0]       word;
   logic [31:0]       shifted;

   assign aligned = {rd_addr[ADDR_W-1:2], 2'b00};

   always_comb begin
      word = '0;
      if (aligned == ADDR_W'(STAT_OFF))
         word = status_w;
      for (int w = 0; w < WORDS; w++) begin
         if (int'(aligned) == IBUF_BASE + 4*w)
            word = ibuf[32*w +: 32];
      end
   end

   assign shifted = word >> {rd_addr[1:0], 3'b000};

   always_comb begin
      if (!rd_en)
         rdata = '0;
      else if (rd_byte)
         rdata = {24'b0, shifted[7:0]};
      else
         rdata = word;
   end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbx_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUF_BYTES = 16,
   parameter int OBUF_BASE = 128,
   parameter int IBUF_BASE = 144
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hst_wr,
   input  logic                   hst_rd,
   input  logic                   hst_rd_byte,
   input  logic [ADDR_W-1:0]      hst_addr,
   input  logic [31:0]            hst_wdata,
   input  logic [3:0]             hst_be,
   output logic [31:0]            hst_rdata,
   output logic                   hst_irq,
   output logic                   ctl_doorbell,
   output logic [31:0]            ctl_cmd,
   output logic [BUF_BYTES*8-1:0] ctl_obuf,
   input  logic                   ctl_done,
   input  logic                   ctl_err,
   input  logic [7:0]             ctl_err_code,
   input  logic [7:0]             ctl_init_id,
   input  logic [BUF_BYTES*8-1:0] ctl_rsp
);

   localparam int WORDS = BUF_BYTES / 4;
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   // Elaboration-time parameter checks
   if (BUF_BYTES < 4 || (BUF_BYTES % 4) != 0) begin : g_bad_bytes
      $error("BUF_BYTES must be a nonzero multiple of 4");
   end
   if ((OBUF_BASE % 4) != 0 || (IBUF_BASE % 4) != 0) begin : g_bad_align
      $error("buffer bases must be word aligned");
   end
   if (OBUF_BASE < 8 || IBUF_BASE < OBUF_BASE + BUF_BYTES) begin : g_bad_overlap
      $error("buffers overlap each other or the command/status words");
   end
   if (IBUF_BASE + BUF_BYTES > (1 << ADDR_W)) begin : g_bad_window
      $error("inbound buffer exceeds the address window");
   end

   logic        cmd_wr;
   logic        obuf_wr;
   logic [IDX_W-1:0] obuf_idx;
   mbx_cmd_t    cmd_q;
   mbx_status_t status;
   logic        load_rsp;
   logic [BUF_BYTES*8-1:0] ibuf_q;

   assign cmd_wr  = hst_wr && (hst_addr == ADDR_W'(CMD_OFF));
   assign obuf_wr = hst_wr && (int'(hst_addr) >= OBUF_BASE)
                           && (int'(hst_addr) <  OBUF_BASE + BUF_BYTES);
   assign obuf_idx = IDX_W'((int'(hst_addr) - OBUF_BASE) >> 2);

   mbx_cmd_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_wdata (hst_wdata),
      .done      (ctl_done),
      .done_err  (ctl_err),
      .done_code (ctl_err_code),
      .done_init (ctl_init_id),
      .cmd_q     (cmd_q),
      .doorbell  (ctl_doorbell),
      .status    (status),
      .irq       (hst_irq),
      .load_rsp  (load_rsp)
   );

   mbx_buf #(.BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_obuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (obuf_wr),
      .wr_idx    (obuf_idx),
      .wr_data   (hst_wdata),
      .wr_be     (hst_be),
      .load      (1'b0),
      .load_data ('0),
      .q         (ctl_obuf)
   );

   mbx_buf #(.BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_ibuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (1'b0),
      .wr_idx    ('0),
      .wr_data   ('0),
      .wr_be     (4'b0000),
      .load      (load_rsp),
      .load_data (ctl_rsp),
      .q         (ibuf_q)
   );

   mbx_rd_mux #(.ADDR_W(ADDR_W), .BYTES(BUF_BYTES), .IBUF_BASE(IBUF_BASE)) u_rd (
      .rd_en    (hst_rd),
      .rd_byte  (hst_rd_byte),
      .rd_addr  (hst_addr),
      .status_w (status),
      .ibuf     (ibuf_q),
      .rdata    (hst_rdata)
   );

   assign ctl_cmd = cmd_q;

   a_r9_reserved_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && !hst_rd_byte && hst_addr == ADDR_W'(STAT_OFF)) |->
         (hst_rdata[31:24] == 8'h00 && hst_rdata[3:2] == 2'b00));

endmodule

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;

   localparam int NB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hst_wr = 1'b0, hst_rd = 1'b0, hst_rd_byte = 1'b0;
   logic [7:0]    hst_addr = '0;
   logic [31:0]   hst_wdata = '0;
   logic [3:0]    hst_be = '0;
   logic [31:0]   hst_rdata;
   logic          hst_irq, ctl_doorbell;
   logic [31:0]   ctl_cmd;
   logic [NB*8-1:0] ctl_obuf;
   logic          ctl_done = 1'b0, ctl_err = 1'b0;
   logic [7:0]    ctl_err_code = '0, ctl_init_id = '0;
   logic [NB*8-1:0] ctl_rsp = '0;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   ipc_mailbox uut (
      .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
      .hst_rd_byte(hst_rd_byte), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
      .hst_be(hst_be), .hst_rdata(hst_rdata), .hst_irq(hst_irq),
      .ctl_doorbell(ctl_doorbell), .ctl_cmd(ctl_cmd), .ctl_obuf(ctl_obuf),
      .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code),
      .ctl_init_id(ctl_init_id), .ctl_rsp(ctl_rsp)
   );

   typedef struct packed {
      logic [31:0] cmd;
      logic        err;
      logic [7:0]  code;
      logic [7:0]  init;
      logic [31:0] seed;
   } vec_t;

   localparam int NV = 4;
   localparam vec_t VEC [NV] = '{
      '{32'h0008_11FF, 1'b0, 8'h00, 8'h3C, 32'hA5A5_0000},
      '{32'h0010_20F4, 1'b1, 8'h5A, 8'h01, 32'h1234_5678},
      '{32'hAB04_F1EF, 1'b1, 8'hFF, 8'hFF, 32'hFFFF_FFF0},
      '{32'h0000_70F8, 1'b0, 8'h00, 8'h80, 32'h0000_0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      hst_wr = 1'b1; hst_addr = a; hst_wdata = d; hst_be = be;
      @(negedge clk);
      hst_wr = 1'b0; hst_be = '0;
   endtask

   task automatic host_read(input logic [7:0] a, input logic byte_rd, output logic [31:0] d);
      hst_rd = 1'b1; hst_rd_byte = byte_rd; hst_addr = a;
      #1;
      d = hst_rdata;
      hst_rd = 1'b0; hst_rd_byte = 1'b0;
   endtask

   task automatic ctl_finish(input logic e, input logic [7:0] c, input logic [7:0] i);
      @(negedge clk);
      ctl_done = 1'b1; ctl_err = e; ctl_err_code = c; ctl_init_id = i;
      @(negedge clk);
      ctl_done = 1'b0;
   endtask

   function automatic logic [31:0] exp_status(input logic [31:0] cmd, input logic e,
                                              input logic [7:0] c, input logic [7:0] i);
      return {8'h00, c, i, cmd[15:12], 2'b00, e, 1'b0};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R1: watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] cmd_a;
      logic [NB*8-1:0] rsp_keep;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      host_read(8'h04, 1'b0, rd); chk("R1 status", rd, 32'h0);
      chk("R1 doorbell", {31'b0, ctl_doorbell}, 32'h0);
      chk("R1 irq", {31'b0, hst_irq}, 32'h0);
      chk("R1 cmd", ctl_cmd, 32'h0);
      for (int k = 0; k < NB/4; k++) begin
         host_read(8'h90 + 8'(4*k), 1'b0, rd); chk("R1 inbound", rd, 32'h0);
      end

      // Table-driven transactions
      for (int v = 0; v < NV; v++) begin
         for (int k = 0; k < NB/4; k++)
            host_write(8'h80 + 8'(4*k), VEC[v].seed + k, 4'hF);
         host_write(8'h00, VEC[v].cmd, 4'hF);
         chk("R2 doorbell high", {31'b0, ctl_doorbell}, 32'h1);
         chk("R2 cmd latched", ctl_cmd, VEC[v].cmd);
         host_read(8'h04, 1'b0, rd); chk("R2 busy", {31'b0, rd[0]}, 32'h1);
         for (int k = 0; k < NB/4; k++)
            chk("R4 outbound", ctl_obuf[32*k +: 32], VEC[v].seed + k);
         host_read(8'h80, 1'b0, rd); chk("R4 outbound read zero", rd, 32'h0);
         @(negedge clk);
         chk("R2 doorbell single", {31'b0, ctl_doorbell}, 32'h0);
         for (int k = 0; k < NB/4; k++)
            ctl_rsp[32*k +: 32] = ~VEC[v].seed + k;
         ctl_finish(VEC[v].err, VEC[v].code, VEC[v].init);
         chk("R7 irq", {31'b0, hst_irq}, {31'b0, VEC[v].cmd[8]});
         host_read(8'h04, 1'b0, rd);
         chk("R5 status", rd, exp_status(VEC[v].cmd, VEC[v].err, VEC[v].code, VEC[v].init));
         chk("R9 reserved status bits", rd & 32'hFF00_000C, 32'h0);
         for (int k = 0; k < NB/4; k++) begin
            host_read(8'h90 + 8'(4*k), 1'b0, rd); chk("R6 inbound word", rd, ~VEC[v].seed + k);
         end
         @(negedge clk);
         chk("R7 irq single", {31'b0, hst_irq}, 32'h0);
      end

      // R6: byte reads at buffer edges
      host_read(8'h9F, 1'b1, rd); chk("R6 byte 0x9F", rd, {24'b0, ctl_rsp[127:120]});
      host_read(8'h91, 1'b1, rd); chk("R6 byte 0x91", rd, {24'b0, ctl_rsp[15:8]});
      host_read(8'h05, 1'b1, rd); chk("R6 status byte", rd, {24'b0, 8'h80});

      // R9: zero reads
      host_read(8'h00, 1'b0, rd); chk("R9 cmd read", rd, 32'h0);
      host_read(8'h40, 1'b0, rd); chk("R9 unmapped", rd, 32'h0);
      host_read(8'hA0, 1'b0, rd); chk("R9 past inbound", rd, 32'h0);
      host_read(8'h8F, 1'b1, rd); chk("R9 outbound byte", rd, 32'h0);
      hst_addr = 8'h90; #1; chk("R9 no read strobe", hst_rdata, 32'h0);

      // R4: byte lanes
      host_write(8'h8C, 32'hDEAD_BEEF, 4'b0010);
      chk("R4 lane write", ctl_obuf[127:96], 32'h0000_BE00 | ((VEC[NV-1].seed + 3) & 32'hFFFF_00FF));

      // R3: command while busy ignored
      cmd_a = 32'h0002_3155;
      host_write(8'h00, cmd_a, 4'hF);
      @(negedge clk);
      host_write(8'h00, 32'h0004_9166, 4'hF);
      chk("R3 no doorbell", {31'b0, ctl_doorbell}, 32'h0);
      chk("R3 cmd kept", ctl_cmd, cmd_a);
      ctl_finish(1'b0, 8'h11, 8'h22);
      host_read(8'h04, 1'b0, rd);
      chk("R3 status echoes first", rd, exp_status(cmd_a, 1'b0, 8'h11, 8'h22));
      chk("R7 irq for ioc", {31'b0, hst_irq}, 32'h1);

      // R8: done while idle ignored
      rsp_keep = ctl_rsp;
      ctl_rsp = ~ctl_rsp;
      @(negedge clk);
      ctl_finish(1'b1, 8'h99, 8'h77);
      chk("R8 no irq", {31'b0, hst_irq}, 32'h0);
      host_read(8'h04, 1'b0, rd);
      chk("R8 status kept", rd, exp_status(cmd_a, 1'b0, 8'h11, 8'h22));
      host_read(8'h90, 1'b0, rd); chk("R8 inbound kept", rd, rsp_keep[31:0]);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule